// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It sits between an external transmit FIFO (first-word-fall-through, read through an empty flag and a pop strobe) and an external receive FIFO (written through a push strobe). When enabled, it takes one word at a time from the transmit side. It shifts the word out on MOSI with the most significant bit first, captures the same number of bits from MISO, and pushes the received word to the receive side. It produces exactly one received word for each word sent.

The serial clock runs at the input clock rate divided by 2×(D+1), where D is a 9-bit divider value. Several settings are inputs: the idle level of the serial clock, which clock edge launches data, whether MISO is captured at the middle or at the end of each bit time, and the word width (8, 16 or 32 bits). All of them are captured when a word is taken, so they can change safely while a word is on the wire. In an optional automatic mode, a registered active-low chip select follows the transmit FIFO: it is held asserted while words are waiting or in flight and released once everything has gone out. When no word is available the engine waits with the serial clock at its idle level. Dropping the enable input abandons the word in flight.

Top module: `spi_eng`

## Requirements
- R1: Each half of a bit time lasts D+1 input clock cycles, where D is the value on `div_i` captured at the pop. A full serial clock period is therefore 2×(D+1) cycles, for any D from 0 to 511.
- R2: When no word is in flight, `sclk_o` equals `cpol_i` (1 means the clock idles high).
- R3: Each bit time has two halves. With `launch_trail_i`=1, the first half is at the idle level and the second half at the active level, so MOSI changes on the active-to-idle edge. With `launch_trail_i`=0, the first half is active and the second half idle, so MOSI changes on the idle-to-active edge. In both cases MOSI holds one bit for a whole bit time.
- R4: `word_sel_i` chooses the width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. The low bits of `tx_data_i` are sent, most significant of them first. `mosi_o` is 0 when idle.
- R5: With `sample_late_i`=0, MISO is captured on the clock edge that ends the first half of a bit time; with 1, on the edge that ends the second half. After the last bit, `rx_push_o` pulses for one cycle with the word right-justified in `rx_data_o` and the upper bits zero.
- R6: When enabled and idle with `tx_empty_i`=0, `tx_pop_o` is high for one cycle and `tx_data_i` is taken in that cycle. The next cycle is the first half of the first bit. With the FIFO empty, no pop occurs and the clock stays idle.
- R7: `busy_o` is high from the cycle after the pop up to and including the last half bit, and falls in the same cycle that `rx_push_o` pulses. At least one idle cycle separates words.
- R8: `cs_n_o` is registered. It is low in the cycle after any cycle with `en_i`=1, `auto_cs_i`=1 and either `tx_empty_i`=0 or a word in flight, and high otherwise. With `auto_cs_i`=0 it stays high.
- R9: A cycle with `en_i`=0 abandons any word in flight. In the next cycle `busy_o` is low, no push occurs for that word, and `tx_pop_o` stays low while `en_i` is 0.
- R10: Changes to `cpol_i`, `launch_trail_i`, `sample_late_i`, `word_sel_i` and `div_i` while a word is in flight do not affect that word.
- R11: After reset `busy_o`=0, `cs_n_o`=1, `rx_push_o`=0 and `mosi_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Engine enable |
| cpol_i | input | 1 | Serial clock idle level |
| launch_trail_i | input | 1 | 1: launch on active-to-idle edge; 0: launch on idle-to-active edge |
| sample_late_i | input | 1 | 1: capture at end of bit time; 0: capture at middle |
| word_sel_i | input | 2 | Word width code (0: 8, 1: 16, 2/3: 32) |
| div_i | input | DIV_W | Clock divider D |
| auto_cs_i | input | 1 | Automatic chip select mode |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| tx_data_i | input | 32 | Transmit FIFO head word |
| tx_pop_o | output | 1 | Transmit FIFO pop strobe |
| rx_push_o | output | 1 | Receive FIFO push strobe |
| rx_data_o | output | 32 | Received word, right-justified |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select, active low |
| busy_o | output | 1 | Word in flight |

## Verification
The bench builds the engine with its default parameters: a 9-bit divider and a 32-bit data path. This makes the full divider range reachable, including the largest value of 511, and all three word widths, including the alias code 3. A behavioural model compares every output on every cycle across all combinations of clock polarity, launch edge and capture point. MISO is driven with a pattern that changes every cycle, so capturing at the middle and capturing at the end give different words. A loopback pass checks that received words match sent words. Directed sequences cover settings changed mid-word, disabling mid-word and manual chip select.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int unsigned WORD_MAX = 32;

    typedef enum logic [1:0] {
        WSEL_8      = 2'd0,
        WSEL_16     = 2'd1,
        WSEL_32     = 2'd2,
        WSEL_32_ALT = 2'd3
    } wsel_e;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_st_e;

    typedef struct packed {
        logic  cpol;
        logic  launch_trail;
        logic  sample_late;
        wsel_e wsel;
    } xfer_cfg_t;

    function automatic int unsigned word_bits(input wsel_e w);
        case (w)
            WSEL_8:  return 8;
            WSEL_16: return 16;
            default: return WORD_MAX;
        endcase
    endfunction

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             half_end_o
);
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (restart_i) begin
            lim_q <= div_i;
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == lim_q) ? '0 : cnt_q + 1'b1;
        end
    end

    assign half_end_o = run_i && (cnt_q == lim_q);

    // R6: a new word never starts on a half-period boundary of a previous one
    p_no_tick_on_load_r6: assert property (@(posedge clk) disable iff (rst)
        restart_i |-> !half_end_o);

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
    import spi_eng_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              tx_empty_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  xfer_cfg_t         cfg_i,
    input  logic              half_end_i,
    input  logic              miso_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              rx_push_o,
    output logic [DATA_W-1:0] rx_data_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    eng_st_e           st_q;
    xfer_cfg_t         cfg_q;
    logic              half_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              rx_push_q;

    int unsigned       cur_bits;
    int unsigned       new_bits;
    logic [IDX_W-1:0]  last_idx;
    logic              sample;
    logic              last_bit;
    logic              active_lvl;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] rx_mask;

    always_comb begin
        cur_bits   = word_bits(cfg_q.wsel);
        new_bits   = word_bits(cfg_i.wsel);
        last_idx   = IDX_W'(cur_bits - 1);
        sample     = half_end_i && (half_q ? cfg_q.sample_late : !cfg_q.sample_late);
        last_bit   = half_end_i && half_q && (idx_q == last_idx);
        rx_next    = sample ? {rx_sh_q[DATA_W-2:0], miso_i} : rx_sh_q;
        rx_mask    = {DATA_W{1'b1}} >> (DATA_W - cur_bits);
        active_lvl = cfg_q.launch_trail ? half_q : ~half_q;
    end

    assign load_o = (st_q == ENG_IDLE) && en_i && !tx_empty_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ENG_IDLE;
            cfg_q     <= '0;
            half_q    <= 1'b0;
            idx_q     <= '0;
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            rx_data_q <= '0;
            rx_push_q <= 1'b0;
        end else begin
            rx_push_q <= 1'b0;
            if (!en_i) begin
                st_q <= ENG_IDLE;
            end else if (st_q == ENG_IDLE) begin
                if (!tx_empty_i) begin
                    st_q    <= ENG_SHIFT;
                    cfg_q   <= cfg_i;
                    half_q  <= 1'b0;
                    idx_q   <= '0;
                    tx_sh_q <= tx_data_i << (DATA_W - new_bits);
                    rx_sh_q <= '0;
                end
            end else if (half_end_i) begin
                rx_sh_q <= rx_next;
                half_q  <= ~half_q;
                if (half_q) begin
                    if (last_bit) begin
                        st_q      <= ENG_IDLE;
                        rx_push_q <= 1'b1;
                        rx_data_q <= rx_next & rx_mask;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        tx_sh_q <= tx_sh_q << 1;
                    end
                end
            end
        end
    end

    assign busy_o    = (st_q == ENG_SHIFT);
    assign sclk_o    = busy_o ? (cfg_q.cpol ^ active_lvl) : cfg_i.cpol;
    assign mosi_o    = busy_o && tx_sh_q[DATA_W-1];
    assign rx_push_o = rx_push_q;
    assign rx_data_o = rx_data_q;

    // R6: a pop always opens a word in the following cycle
    p_pop_starts_word_r6: assert property (@(posedge clk) disable iff (rst)
        load_o |=> busy_o);

    // R7: the push strobe coincides with the end of busy
    p_push_closes_word_r7: assert property (@(posedge clk) disable iff (rst)
        rx_push_o |-> (!busy_o && $past(busy_o)));

    // R9: disabling ends the word with no push
    p_disable_stops_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!busy_o && !rx_push_o));

    // R1: the serial clock only moves on a half-period boundary
    p_sclk_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !$past(half_end_i)) |-> $stable(sclk_o));

    // R3: output data holds for a full bit time
    p_mosi_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !($past(half_end_i) && $past(half_q))) |-> $stable(mosi_o));

endmodule

// File: rtl/spi_eng_cs.sv
module spi_eng_cs (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic auto_i,
    input  logic tx_empty_i,
    input  logic busy_i,
    output logic cs_n_o
);
    logic cs_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= !(en_i && auto_i && (!tx_empty_i || busy_i));
        end
    end

    assign cs_n_o = cs_n_q;

    // R8: manual mode never asserts chip select
    p_manual_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
        !auto_i |=> cs_n_o);

endmodule

// File: rtl/spi_eng.sv
module spi_eng
    import spi_eng_pkg::*;
#(
    parameter int unsigned DIV_W  = 9,
    parameter int unsigned DATA_W = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              cpol_i,
    input  logic              launch_trail_i,
    input  logic              sample_late_i,
    input  logic [1:0]        word_sel_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              auto_cs_i,
    input  logic              tx_empty_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              cs_n_o,
    output logic              busy_o
);
    xfer_cfg_t live_cfg;
    logic      half_end;
    logic      load;
    logic      busy;

    always_comb begin
        live_cfg.cpol         = cpol_i;
        live_cfg.launch_trail = launch_trail_i;
        live_cfg.sample_late  = sample_late_i;
        live_cfg.wsel         = wsel_e'(word_sel_i);
    end

    spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (load),
        .run_i      (busy),
        .div_i      (div_i),
        .half_end_o (half_end)
    );

    spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .tx_empty_i (tx_empty_i),
        .tx_data_i  (tx_data_i),
        .cfg_i      (live_cfg),
        .half_end_i (half_end),
        .miso_i     (miso_i),
        .load_o     (load),
        .busy_o     (busy),
        .sclk_o     (sclk_o),
        .mosi_o     (mosi_o),
        .rx_push_o  (rx_push_o),
        .rx_data_o  (rx_data_o)
    );

    spi_eng_cs u_cs (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .auto_i     (auto_cs_i),
        .tx_empty_i (tx_empty_i),
        .busy_i     (busy),
        .cs_n_o     (cs_n_o)
    );

    assign tx_pop_o = load;
    assign busy_o   = busy;

endmodule

// File: tb/spi_eng_tb_top.sv
module spi_eng_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        en = 1'b0, cpol = 1'b0, lt = 1'b1, sl = 1'b0, auto_cs = 1'b1;
    logic [1:0]  wsel = 2'd0;
    logic [8:0]  div = 9'd0;
    logic        miso = 1'b0, tx_empty = 1'b1;
    logic [31:0] tx_data = 32'h0;
    logic        tx_pop, rx_push, sclk, mosi, cs_n, busy;
    logic [31:0] rx_data;

    spi_eng dut_i (
        .clk(clk), .rst(rst), .en_i(en), .cpol_i(cpol), .launch_trail_i(lt),
        .sample_late_i(sl), .word_sel_i(wsel), .div_i(div), .auto_cs_i(auto_cs),
        .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
        .rx_push_o(rx_push), .rx_data_o(rx_data), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso), .cs_n_o(cs_n), .busy_o(busy)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] txq[$];
    logic [31:0] sbq[$];
    bit   pend = 0, loop_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int   cur_div = 0, run = 0;
    logic prev_sclk = 0, prev_busy = 0;

    // behavioural reference state
    bit m_act = 0, m_push = 0, m_csn = 1, was_act, m_cp, m_ck, m_sm;
    int m_half, m_cnt, m_bit, m_nb, m_dv;
    logic [31:0] m_w, m_acc, m_rxd = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_push = 0; m_csn = 1; m_rxd = 0;
        end else begin
            was_act = m_act;
            m_push = 0;
            if (!en) m_act = 0;
            else if (!m_act) begin
                if (!tx_empty) begin
                    m_act = 1; m_w = tx_data;
                    m_nb = (wsel == 2'd0) ? 8 : (wsel == 2'd1) ? 16 : 32;
                    m_half = 0; m_cnt = 0; m_bit = 0; m_acc = 0;
                    m_cp = cpol; m_ck = lt; m_sm = sl; m_dv = int'(div);
                end
            end else if (m_cnt == m_dv) begin
                m_cnt = 0;
                if ((m_half == 0) != m_sm) m_acc = {m_acc[30:0], miso};
                if (m_half == 1) begin
                    if (m_bit == m_nb - 1) begin
                        m_act = 0; m_push = 1;
                        m_rxd = (m_nb == 32) ? m_acc : (m_acc & ((32'h1 << m_nb) - 1));
                    end else m_bit++;
                end
                m_half = 1 - m_half;
            end else m_cnt++;
            m_csn = !(en && auto_cs && (!tx_empty || was_act));
        end
    end

    always @(negedge clk) begin
        logic e_sclk, e_mosi, e_pop;
        if (pend) void'(txq.pop_front());
        tx_empty = (txq.size() == 0);
        tx_data  = tx_empty ? 32'hDEAD_BEEF : txq[0];
        if (loop_mode) miso = mosi;
        else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            miso = lfsr[0];
        end
        #1;
        if (!rst) begin
            e_sclk = m_act ? (m_cp ^ (m_ck ? (m_half == 1) : (m_half == 0))) : cpol;
            e_mosi = m_act ? m_w[m_nb - 1 - m_bit] : 1'b0;
            e_pop  = !m_act && en && !tx_empty;
            chk("R1 R2 R3 R10 sclk", sclk, e_sclk);
            chk("R3 R4 mosi", mosi, e_mosi);
            chk("R6 tx_pop", tx_pop, e_pop);
            chk("R7 R9 busy", busy, m_act);
            chk("R8 cs_n", cs_n, m_csn);
            chk("R5 rx_push", rx_push, m_push);
            if (m_push) chk("R4 R5 rx_data", rx_data, m_rxd);
            if (loop_mode && rx_push) begin
                if (sbq.size() == 0) chk("R5 loopback extra push", 1, 0);
                else chk("R4 R5 loopback word", rx_data, sbq.pop_front());
            end
            // R1: independent half-period length measurement
            if (!busy) run = 0;
            else if (!prev_busy) run = 1;
            else if (sclk != prev_sclk) begin
                chk("R1 half period", run, cur_div + 1);
                run = 1;
            end else run++;
            prev_sclk = sclk; prev_busy = busy;
        end
        pend = tx_pop;
    end

    task automatic set_mode(input bit p, input bit l, input bit s, input logic [1:0] w,
                            input int d, input bit a);
        @(negedge clk);
        cpol = p; lt = l; sl = s; wsel = w; div = d[8:0]; cur_div = d; auto_cs = a;
    endtask

    task automatic drain();
        do @(negedge clk); while (txq.size() != 0 || m_act || pend);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #2;
        // R11: reset state
        chk("R11 busy", busy, 0);
        chk("R11 cs_n", cs_n, 1);
        chk("R11 rx_push", rx_push, 0);
        chk("R11 mosi", mosi, 0);
        chk("R2 idle sclk", sclk, cpol);
        @(negedge clk); rst = 0; en = 1;

        set_mode(0, 1, 0, 2'd0, 0, 1);
        txq.push_back(32'h0000_00A5); txq.push_back(32'h0000_003C); txq.push_back(32'h0000_00FF);
        drain();

        set_mode(1, 0, 1, 2'd1, 2, 1);
        txq.push_back(32'h0000_8001); txq.push_back(32'h0000_1234);
        drain();

        set_mode(0, 0, 0, 2'd2, 1, 0);   // R8 manual chip select
        txq.push_back(32'hF00D_C0DE);
        drain();

        set_mode(1, 1, 1, 2'd3, 4, 1);   // R4 alias code 3 gives 32 bits
        txq.push_back(32'h8000_0001);
        drain();

        set_mode(0, 1, 1, 2'd0, 511, 1); // R1 largest divider
        txq.push_back(32'h0000_0096);
        drain();

        // R4 R5 loopback: received words equal sent words
        loop_mode = 1;
        set_mode(0, 1, 0, 2'd0, 1, 1);
        txq.push_back(32'hFFFF_FF5A); sbq.push_back(32'h0000_005A);
        txq.push_back(32'h0000_00C3); sbq.push_back(32'h0000_00C3);
        drain();
        set_mode(1, 0, 1, 2'd1, 0, 1);
        txq.push_back(32'h0001_BEEF); sbq.push_back(32'h0000_BEEF);
        drain();
        chk("R5 loopback all received", sbq.size(), 0);
        loop_mode = 0;

        // R10: settings changed mid-word leave the word alone
        set_mode(0, 1, 0, 2'd1, 3, 1);
        txq.push_back(32'h0000_A5A5);
        repeat (12) @(negedge clk);
        cpol = 1; lt = 0; sl = 1; wsel = 2'd0; div = 9'd7;
        drain();

        // R9: disable mid-word
        set_mode(0, 1, 0, 2'd0, 2, 1);
        txq.push_back(32'h0000_0011); txq.push_back(32'h0000_0022);
        repeat (15) @(negedge clk);
        en = 0;
        @(negedge clk); #2;
        chk("R9 busy after disable", busy, 0);
        chk("R9 no push after disable", rx_push, 0);
        chk("R9 no pop while disabled", tx_pop, 0);
        repeat (3) @(negedge clk);
        en = 1;
        drain();

        summary();
        $finish;
    end

endmodule